// File: doc/BRIEF.md
# Master-Slave Gated Timer Pair

This block holds two up-counting timers, a master and a slave, that advance on one shared prescaled tick, so the two counters stay aligned to the same cycle. The master produces a trigger output. A select field routes one of two signals onto it: the master's own run enable, or a compare reference that is high while the master counter is below a programmable compare value.

The slave picks its trigger input with a select field. In gated mode the slave counts only on ticks where that trigger is high and its own enable is set. It records every change of the trigger in a flag, which software clears. Software reaches the control fields, reload values, compare value, direct counter loads and counter-reset pulses through one write port. Both counters, the trigger output, the compare reference and the flag are visible as outputs.

A typical use gates the slave with the master's run state. Software loads the slave with a starting value such as E7h and then starts the master. The slave then steps E7h, E8h, E9h and so on for as long as the master runs, and it freezes at the first tick after the master is stopped.

Top module: `gated_timer_pair`

## Requirements
- R1: Counters change only in cycles where the shared prescaler reaches TICK_DIV-1. The prescaler is a free-running count from 0 after reset, so a tick falls on every TICK_DIV-th cycle. A register write is the one exception.
- R2: Address 0 holds the master control: bit 0 is the enable and bits 6:4 are the trigger-output source. While enabled, the master counter adds 1 on each tick. After reaching its reload value (address 1) it returns to 0.
- R3: The compare reference output is 1 while the master counter is below the compare value at address 2, and 0 otherwise.
- R4: The trigger output carries the master enable when the source field is 3'b001 and the compare reference when it is 3'b100. For every other value it is 0.
- R5: Address 4 holds the slave control: bit 0 is the enable, bits 3:1 the trigger select and bits 6:4 the slave mode. A trigger select of 3'b001 feeds the master's trigger output to the slave. Any other value feeds a constant 0.
- R6: In slave mode 3'b101 (gated), the slave counter advances on a tick only when its enable is 1 and its trigger is 1. Otherwise it holds.
- R7: In every other slave mode, the slave counter advances on each tick while its enable is 1. It wraps to 0 after reaching the slave reload value at address 5.
- R8: Writing a control word with bit 7 set clears that timer's counter to 0. A write to address 3 (master) or address 6 (slave) loads the counter, and counting continues from the loaded value. Both kinds of write take priority over a tick in the same cycle.
- R9: In gated mode, the trigger flag is set in the cycle after the slave trigger changes level. Writing address 7 with bit 0 equal to 0 clears it; writing bit 0 equal to 1 has no effect. When a set and a clear fall in the same cycle, the set wins.
- R10: After reset, both counters, the flag, the trigger output and both enables are 0, the compare value is 0, and both reload values are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Write data |
| m_cnt_o | output | CNT_W | Master counter |
| s_cnt_o | output | CNT_W | Slave counter |
| oc_ref_o | output | 1 | Master compare reference |
| trg_out_o | output | 1 | Master trigger output |
| trig_flag_o | output | 1 | Slave trigger-change flag |

## Verification
The bench builds the block with CNT_W = 8 and TICK_DIV = 3. This makes every tick phase recur within a few cycles, and it lets the slave run from E7h through a short reload of EAh and wrap within one run. With these values the bench sweeps all eight master source codes, two trigger selects and all eight slave modes. In each combination it stops the master part-way through, so the gated hold, the wrap, the flag edges and the write-over-tick cases all come up within a few thousand cycles.

// File: rtl/gated_timer_pair.sv
module gated_timer_pair #(
  parameter int CNT_W    = 16,
  parameter int TICK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] m_cnt_o,
  output logic [CNT_W-1:0] s_cnt_o,
  output logic             oc_ref_o,
  output logic             trg_out_o,
  output logic             trig_flag_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [2:0] SRC_EN   = 3'b001;
  localparam logic [2:0] SRC_OC   = 3'b100;
  localparam logic [2:0] SEL_MST  = 3'b001;
  localparam logic [2:0] MODE_GATE = 3'b101;

  logic [PW-1:0]    pcnt;
  logic             m_en, s_en, trig_q;
  logic [2:0]       m_src, s_sel, s_mode;
  logic [CNT_W-1:0] m_arr, m_cmp, s_arr;

  wire tick    = (pcnt == PW'(TICK_DIV - 1));
  wire m_ctl   = wr_en && wr_addr == 3'd0;
  wire s_ctl   = wr_en && wr_addr == 3'd4;
  wire m_ug    = m_ctl && wr_data[7];
  wire s_ug    = s_ctl && wr_data[7];
  wire m_load  = wr_en && wr_addr == 3'd3;
  wire s_load  = wr_en && wr_addr == 3'd6;
  wire m_wr    = m_ug || m_load;
  wire s_wr    = s_ug || s_load;
  wire gated   = (s_mode == MODE_GATE);
  wire trig_in = (s_sel == SEL_MST) && trg_out_o;
  wire s_adv   = tick && s_en && (!gated || trig_in);

  assign oc_ref_o  = m_cnt_o < m_cmp;
  assign trg_out_o = (m_src == SRC_EN) ? m_en : (m_src == SRC_OC) ? oc_ref_o : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) pcnt <= '0;
    else        pcnt <= tick ? '0 : pcnt + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_en  <= 1'b0;
      m_src <= 3'b000;
      m_arr <= '1;
      m_cmp <= '0;
      s_en  <= 1'b0;
      s_sel <= 3'b000;
      s_mode <= 3'b000;
      s_arr <= '1;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: begin m_en <= wr_data[0]; m_src <= wr_data[6:4]; end
        3'd1: m_arr <= wr_data;
        3'd2: m_cmp <= wr_data;
        3'd4: begin s_en <= wr_data[0]; s_sel <= wr_data[3:1]; s_mode <= wr_data[6:4]; end
        3'd5: s_arr <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             m_cnt_o <= '0;
    else if (m_ug)          m_cnt_o <= '0;
    else if (m_load)        m_cnt_o <= wr_data;
    else if (tick && m_en)  m_cnt_o <= (m_cnt_o == m_arr) ? '0 : m_cnt_o + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      s_cnt_o <= '0;
    else if (s_ug)   s_cnt_o <= '0;
    else if (s_load) s_cnt_o <= wr_data;
    else if (s_adv)  s_cnt_o <= (s_cnt_o == s_arr) ? '0 : s_cnt_o + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q      <= 1'b0;
      trig_flag_o <= 1'b0;
    end else begin
      trig_q <= trig_in;
      if (gated && (trig_in != trig_q))            trig_flag_o <= 1'b1;
      else if (wr_en && wr_addr == 3'd7 && !wr_data[0]) trig_flag_o <= 1'b0;
    end
  end

  AST_MASTER_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !m_wr) |=> $stable(m_cnt_o)); // R1
  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (gated && !trig_in && !s_wr) |=> $stable(s_cnt_o)); // R6
  AST_SLAVE_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_en && !s_wr) |=> $stable(s_cnt_o)); // R6
  AST_UG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    m_ug |=> (m_cnt_o == '0)); // R8
  AST_FLAG_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (gated && (trig_in != trig_q)) |=> trig_flag_o); // R9
endmodule

// File: tb/gated_timer_pair_bench.sv
module gated_timer_pair_bench;
  localparam int W = 8;
  localparam int DIV = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] m_cnt, s_cnt;
  logic oc_ref, trg_out, flag;

  always #4 clk = ~clk;

  gated_timer_pair #(.CNT_W(W), .TICK_DIV(DIV)) u_gated_timer_pair (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .m_cnt_o(m_cnt), .s_cnt_o(s_cnt), .oc_ref_o(oc_ref), .trg_out_o(trg_out),
    .trig_flag_o(flag));

  int checks = 0, fails = 0;
  bit done = 0;

  // expected state, maintained from the requirements
  int e_ph, e_m, e_s, e_marr, e_mcmp, e_sarr, e_src, e_sel, e_mode;
  bit e_men, e_sen, e_flag, e_tq;

  function automatic bit exp_oc();
    return e_m < e_mcmp;
  endfunction
  function automatic bit exp_trg();
    if (e_src == 1) return e_men;
    if (e_src == 4) return exp_oc();
    return 1'b0;
  endfunction
  function automatic bit exp_tin();
    return (e_sel == 1) && exp_trg();
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      e_ph = 0; e_m = 0; e_s = 0; e_marr = 255; e_mcmp = 0; e_sarr = 255;
      e_src = 0; e_sel = 0; e_mode = 0; e_men = 0; e_sen = 0; e_flag = 0; e_tq = 0;
    end else begin
      bit tk, tin, gt;
      int d;
      tk = (e_ph == DIV - 1);
      tin = exp_tin();
      gt = (e_mode == 5);
      d = int'(wr_data);
      if (wr_en && wr_addr == 0 && d[7]) e_m = 0;
      else if (wr_en && wr_addr == 3) e_m = d;
      else if (tk && e_men) e_m = (e_m == e_marr) ? 0 : e_m + 1;
      if (wr_en && wr_addr == 4 && d[7]) e_s = 0;
      else if (wr_en && wr_addr == 6) e_s = d;
      else if (tk && e_sen && (!gt || tin)) e_s = (e_s == e_sarr) ? 0 : e_s + 1;
      if (gt && tin != e_tq) e_flag = 1;
      else if (wr_en && wr_addr == 7 && !d[0]) e_flag = 0;
      e_tq = tin;
      if (wr_en) begin
        case (wr_addr)
          0: begin e_men = d[0]; e_src = (d >> 4) & 7; end
          1: e_marr = d;
          2: e_mcmp = d;
          4: begin e_sen = d[0]; e_sel = (d >> 1) & 7; e_mode = (d >> 4) & 7; end
          5: e_sarr = d;
          default: ;
        endcase
      end
      e_ph = tk ? 0 : e_ph + 1;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    string st;
    st = (e_mode == 5) ? ((e_sel == 1) ? "R6" : "R5") : "R7";
    chk("R1 R2", "master count", int'(m_cnt), e_m);
    chk(st, "slave count", int'(s_cnt), e_s);
    chk("R3", "compare ref", int'(oc_ref), int'(exp_oc()));
    chk("R4", "trigger out", int'(trg_out), int'(exp_trg()));
    chk("R9", "trigger flag", int'(flag), int'(e_flag));
  endtask

  task automatic step(bit we, int a, int d);
    @(negedge clk);
    check_all();
    wr_en = we; wr_addr = 3'(a); wr_data = W'(d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "reset master", int'(m_cnt), 0);
    chk("R10", "reset slave", int'(s_cnt), 0);
    chk("R10", "reset flag", int'(flag), 0);
    chk("R10", "reset trigger", int'(trg_out), 0);
    chk("R10", "reset compare ref", int'(oc_ref), 0);
    rst_n = 1'b1;

    // directed: gate slave with master run state, load E7h
    step(1, 4, 8'h80 | (5 << 4) | (1 << 1) | 1);
    step(1, 6, 8'hE7);
    step(1, 0, (1 << 4) | 1);
    step(0, 0, 0);
    chk("R8", "slave load value", int'(s_cnt), 8'hE7);
    for (int i = 0; i < 9; i++) step(0, 0, 0);
    chk("R6", "slave advanced while master runs", int'(s_cnt), 8'hEA);
    step(1, 0, 1 << 4);
    for (int i = 0; i < 6; i++) step(0, 0, 0);
    chk("R6", "slave frozen after master stop", int'(s_cnt), e_s);
    step(1, 7, 1);
    step(0, 0, 0);
    chk("R9", "write 1 leaves flag", int'(flag), 1);
    step(1, 7, 0);
    step(0, 0, 0);
    chk("R9", "write 0 clears flag", int'(flag), 0);

    // sweep of source, select and mode
    for (int src = 0; src < 8; src++)
      for (int sel = 0; sel < 2; sel++)
        for (int md = 0; md < 8; md++) begin
          step(1, 1, 5 + src);
          step(1, 2, 2 + (md % 4));
          step(1, 5, 8'hEA);
          step(1, 0, (src << 4) | 8'h80 | 1);
          step(1, 4, 8'h80 | (md << 4) | (sel << 1) | ((md == 3) ? 0 : 1));
          step(1, 6, 8'hE7);
          step(1, 7, 0);
          for (int i = 0; i < 14; i++) step(0, 0, 0);
          step(1, 0, src << 4);
          for (int i = 0; i < 7; i++) step(0, 0, 0);
          step(1, 3, 3);
        end
    step(0, 0, 0);
    @(negedge clk);
    check_all();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule